// File: doc/BRIEF.md
# Multi-Level Trigger Sequencer

This block decides when a logic-analyzer capture path keeps samples. On every sample clock it receives a parallel vector made of a data bus, an address bus and a few control lines. A short program of up to four levels sets the decision. Each level tests the incoming sample against its own condition and then branches to a success or a failure level. Levels can branch backwards, so the program can express searches such as "find a start byte, then see a burst of write strobes inside a window, otherwise start over".

Each level has several parts: masked comparisons of data, address and control, joined by AND or OR; an optional rising-edge term on one chosen control line; an occurrence counter; and a 24-bit sample timer. The timer acts either as a timeout window or as a delay that follows the count. A level of kind store is the final stage. It raises a one-cycle store strobe for each qualifying sample until the buffer reports full. The block reports the active level, a sticky triggered flag and a done flag. A synchronous arm input restarts the program.

The sequencer has five states. ST_IDLE is the state after reset. ST_MATCH counts events of a counting level. ST_HOLD waits out the delay of a delay level. ST_STORE emits store strobes. ST_DONE is entered once the buffer is full. The transitions are:
- arm: any state moves to level 0, into ST_STORE if level 0 is a store level and into ST_MATCH otherwise.
- count hit: ST_MATCH moves to the success level, or to ST_HOLD for a delay level.
- window expiry: ST_MATCH moves to the failure level.
- delay expiry: ST_HOLD moves to the success level.
- buffer full: ST_STORE moves to ST_DONE.

Top module: `trig_sequencer`

## Requirements
- R1: After reset, level_o is 0 and store_o, triggered_o and done_o are low. Until the first arm, samples have no effect, even samples that match level 0.
- R2: arm_i synchronously moves the sequencer to level 0 and clears done_o and triggered_o. It also clears counters, timer and edge history. The exception is level 0 of kind store, which sets triggered_o again on entry.
- R3: Only the active level's condition is tested. The condition joins the enabled masked terms (term-enable bit 0 = data, bit 1 = addr, bit 2 = ctl) by AND (or-mode 0; no terms enabled gives true) or by OR (or-mode 1). The level is left once its event has occurred count times, where count 0 counts as 1.
- R4: The sample that completes a level is never tested against the next level. A delay level tests none of the samples that arrive during its wait.
- R5: With edge-enable set, an event also needs a rise on the selected control line: low in the previous valid sample of this level and high in the current one. Edge history is cleared on every level change, so the first sample in a level never gives a rise.
- R6: For a level of kind window (kind code 1) with a nonzero reload R, the timer starts at level entry. If the count is reached on or before the R-th valid sample, the level goes to its success level. Otherwise it goes to its failure level on the R-th sample. Reload 0 disables the timeout.
- R7: For a level of kind delay (kind code 2), reaching the count starts a wait of R valid samples. After the R-th sample the level goes to its success level. With R = 0 it goes on at once.
- R8: In a store level (kind code 3), store_o is high for one clock after each valid sample that meets the condition, as long as buf_full_i is low.
- R9: buf_full_i high in a store level sets done_o. From then on no further store strobes occur, and done_o stays set until arm.
- R10: triggered_o is set when a store level is entered and stays set until the next arm.
- R11: level_o shows the new level one clock after the sample that causes a transition. Seek levels (kind code 0) go to their success level as soon as the count is reached.
- R12: Samples with smp_vld_i low advance neither counters, timers nor levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_i | input | 1 | Synchronous reset, active high |
| arm_i | input | 1 | Restart program at level 0 |
| smp_vld_i | input | 1 | Sample qualifier |
| smp_data_i | input | DW | Sampled data bus |
| smp_addr_i | input | AW | Sampled address bus |
| smp_ctl_i | input | CW | Sampled control lines |
| buf_full_i | input | 1 | Capture buffer full |
| cfg_kind_i | input | NLVL*2 | Level kind: 0 seek, 1 window, 2 delay, 3 store |
| cfg_term_en_i | input | NLVL*3 | Term enables (data, addr, ctl) |
| cfg_or_mode_i | input | NLVL | 1 = OR of terms, 0 = AND |
| cfg_data_val_i | input | NLVL*DW | Data compare value |
| cfg_data_mask_i | input | NLVL*DW | Data compare mask |
| cfg_addr_val_i | input | NLVL*AW | Address compare value |
| cfg_addr_mask_i | input | NLVL*AW | Address compare mask |
| cfg_ctl_val_i | input | NLVL*CW | Control compare value |
| cfg_ctl_mask_i | input | NLVL*CW | Control compare mask |
| cfg_edge_en_i | input | NLVL | Require rising edge |
| cfg_edge_sel_i | input | NLVL*SELW | Control line for edge term |
| cfg_count_i | input | NLVL*CNTW | Occurrence count |
| cfg_timer_i | input | NLVL*TMRW | Window or delay reload in samples |
| cfg_goto_ok_i | input | NLVL*LW | Success level |
| cfg_goto_fail_i | input | NLVL*LW | Failure level |
| store_o | output | 1 | Store strobe |
| triggered_o | output | 1 | Store level reached |
| level_o | output | LW | Active level |
| done_o | output | 1 | Capture finished |

## Verification
The hardest case to reach from the ports is a count that completes on the very sample on which the window runs out. Close behind it is the cleared edge history, where a control line that is already high on entry to a level must not count as a rise. The bench reaches both by writing out every toggle of the write line sample by sample. It places the fourth rise exactly on the tenth sample of a ten-sample window. It also enters the edge level on a sample with the line low and then drives it high first, so that a stale history would give one extra rise and move the level early. Invalid samples placed inside the window, and a delay level fed samples that would satisfy the next level, show that neither the timer nor the wait counts those samples.

// File: rtl/trig_pkg.sv
package trig_pkg;

    typedef enum logic [1:0] {
        KIND_SEEK   = 2'd0,
        KIND_WINDOW = 2'd1,
        KIND_DELAY  = 2'd2,
        KIND_STORE  = 2'd3
    } lvl_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MATCH,
        ST_HOLD,
        ST_STORE,
        ST_DONE
    } seq_state_e;

    localparam int TERM_DATA = 0;
    localparam int TERM_ADDR = 1;
    localparam int TERM_CTL  = 2;
    localparam int TERM_N    = 3;

endpackage

// File: rtl/trig_cfg_sel.sv
module trig_cfg_sel
    import trig_pkg::*;
#(
    parameter int NLVL = 4,
    parameter int DW   = 16,
    parameter int AW   = 16,
    parameter int CW   = 4,
    parameter int CNTW = 8,
    parameter int TMRW = 24,
    localparam int LW   = (NLVL > 1) ? $clog2(NLVL) : 1,
    localparam int SELW = (CW > 1) ? $clog2(CW) : 1
) (
    input  logic [LW-1:0]          lvl_i,
    input  logic [LW-1:0]          tgt_lvl_i,
    input  logic [NLVL*2-1:0]      kind_i,
    input  logic [NLVL*TERM_N-1:0] term_en_i,
    input  logic [NLVL-1:0]        or_mode_i,
    input  logic [NLVL*DW-1:0]     data_val_i,
    input  logic [NLVL*DW-1:0]     data_mask_i,
    input  logic [NLVL*AW-1:0]     addr_val_i,
    input  logic [NLVL*AW-1:0]     addr_mask_i,
    input  logic [NLVL*CW-1:0]     ctl_val_i,
    input  logic [NLVL*CW-1:0]     ctl_mask_i,
    input  logic [NLVL-1:0]        edge_en_i,
    input  logic [NLVL*SELW-1:0]   edge_sel_i,
    input  logic [NLVL*CNTW-1:0]   count_i,
    input  logic [NLVL*TMRW-1:0]   timer_i,
    input  logic [NLVL*LW-1:0]     goto_ok_i,
    input  logic [NLVL*LW-1:0]     goto_fail_i,
    output lvl_kind_e              kind_o,
    output lvl_kind_e              tgt_kind_o,
    output logic [TERM_N-1:0]      term_en_o,
    output logic                   or_mode_o,
    output logic [DW-1:0]          data_val_o,
    output logic [DW-1:0]          data_mask_o,
    output logic [AW-1:0]          addr_val_o,
    output logic [AW-1:0]          addr_mask_o,
    output logic [CW-1:0]          ctl_val_o,
    output logic [CW-1:0]          ctl_mask_o,
    output logic                   edge_en_o,
    output logic [SELW-1:0]        edge_sel_o,
    output logic [CNTW-1:0]        count_o,
    output logic [TMRW-1:0]        timer_o,
    output logic [LW-1:0]          goto_ok_o,
    output logic [LW-1:0]          goto_fail_o
);

    logic [1:0]        kd [NLVL];
    logic [TERM_N-1:0] te [NLVL];
    logic [DW-1:0]     dv [NLVL];
    logic [DW-1:0]     dm [NLVL];
    logic [AW-1:0]     av [NLVL];
    logic [AW-1:0]     am [NLVL];
    logic [CW-1:0]     cv [NLVL];
    logic [CW-1:0]     cm [NLVL];
    logic [SELW-1:0]   es [NLVL];
    logic [CNTW-1:0]   cn [NLVL];
    logic [TMRW-1:0]   tm [NLVL];
    logic [LW-1:0]     gk [NLVL];
    logic [LW-1:0]     gf [NLVL];

    for (genvar g = 0; g < NLVL; g++) begin : g_unpack
        assign kd[g] = kind_i[g*2 +: 2];
        assign te[g] = term_en_i[g*TERM_N +: TERM_N];
        assign dv[g] = data_val_i[g*DW +: DW];
        assign dm[g] = data_mask_i[g*DW +: DW];
        assign av[g] = addr_val_i[g*AW +: AW];
        assign am[g] = addr_mask_i[g*AW +: AW];
        assign cv[g] = ctl_val_i[g*CW +: CW];
        assign cm[g] = ctl_mask_i[g*CW +: CW];
        assign es[g] = edge_sel_i[g*SELW +: SELW];
        assign cn[g] = count_i[g*CNTW +: CNTW];
        assign tm[g] = timer_i[g*TMRW +: TMRW];
        assign gk[g] = goto_ok_i[g*LW +: LW];
        assign gf[g] = goto_fail_i[g*LW +: LW];
    end

    assign kind_o      = lvl_kind_e'(kd[lvl_i]);
    assign tgt_kind_o  = lvl_kind_e'(kd[tgt_lvl_i]);
    assign term_en_o   = te[lvl_i];
    assign or_mode_o   = or_mode_i[lvl_i];
    assign data_val_o  = dv[lvl_i];
    assign data_mask_o = dm[lvl_i];
    assign addr_val_o  = av[lvl_i];
    assign addr_mask_o = am[lvl_i];
    assign ctl_val_o   = cv[lvl_i];
    assign ctl_mask_o  = cm[lvl_i];
    assign edge_en_o   = edge_en_i[lvl_i];
    assign edge_sel_o  = es[lvl_i];
    assign count_o     = cn[lvl_i];
    assign timer_o     = tm[lvl_i];
    assign goto_ok_o   = gk[lvl_i];
    assign goto_fail_o = gf[lvl_i];

endmodule

// File: rtl/trig_cond.sv
module trig_cond
    import trig_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 16,
    parameter int CW = 4,
    localparam int SELW = (CW > 1) ? $clog2(CW) : 1
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              smp_vld_i,
    input  logic [DW-1:0]     smp_data_i,
    input  logic [AW-1:0]     smp_addr_i,
    input  logic [CW-1:0]     smp_ctl_i,
    input  logic              hist_clr_i,
    input  logic [TERM_N-1:0] term_en_i,
    input  logic              or_mode_i,
    input  logic [DW-1:0]     data_val_i,
    input  logic [DW-1:0]     data_mask_i,
    input  logic [AW-1:0]     addr_val_i,
    input  logic [AW-1:0]     addr_mask_i,
    input  logic [CW-1:0]     ctl_val_i,
    input  logic [CW-1:0]     ctl_mask_i,
    input  logic              edge_en_i,
    input  logic [SELW-1:0]   edge_sel_i,
    output logic              match_o,
    output logic              rise_o,
    output logic              event_o
);

    logic [TERM_N-1:0] hit;
    logic              all_hit;
    logic              any_hit;
    logic [CW-1:0]     prev_ctl_q;
    logic              hist_vld_q;

    assign hit[TERM_DATA] = ((smp_data_i ^ data_val_i) & data_mask_i) == '0;
    assign hit[TERM_ADDR] = ((smp_addr_i ^ addr_val_i) & addr_mask_i) == '0;
    assign hit[TERM_CTL]  = ((smp_ctl_i  ^ ctl_val_i)  & ctl_mask_i)  == '0;

    assign all_hit = &(hit | ~term_en_i);
    assign any_hit = |(hit & term_en_i);
    assign match_o = or_mode_i ? any_hit : all_hit;

    always_ff @(posedge clk_i) begin
        if (rst_i || hist_clr_i) begin
            hist_vld_q <= 1'b0;
            prev_ctl_q <= '0;
        end else if (smp_vld_i) begin
            hist_vld_q <= 1'b1;
            prev_ctl_q <= smp_ctl_i;
        end
    end

    assign rise_o  = hist_vld_q && !prev_ctl_q[edge_sel_i] && smp_ctl_i[edge_sel_i];
    assign event_o = edge_en_i ? (rise_o && match_o) : match_o;

    assert_no_edge_after_clear_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        hist_clr_i |=> !rise_o);

endmodule

// File: rtl/trig_seq_fsm.sv
module trig_seq_fsm
    import trig_pkg::*;
#(
    parameter int NLVL = 4,
    parameter int CNTW = 8,
    parameter int TMRW = 24,
    localparam int LW = (NLVL > 1) ? $clog2(NLVL) : 1
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            arm_i,
    input  logic            smp_vld_i,
    input  logic            buf_full_i,
    input  logic            event_i,
    input  logic            match_i,
    input  lvl_kind_e       kind_i,
    input  lvl_kind_e       tgt_kind_i,
    input  logic [CNTW-1:0] count_i,
    input  logic [TMRW-1:0] timer_i,
    input  logic [LW-1:0]   goto_ok_i,
    input  logic [LW-1:0]   goto_fail_i,
    output logic [LW-1:0]   tgt_lvl_o,
    output logic            hist_clr_o,
    output logic            store_o,
    output logic            triggered_o,
    output logic [LW-1:0]   level_o,
    output logic            done_o
);

    seq_state_e      state_q, state_d;
    logic [LW-1:0]   lvl_q, lvl_d;
    logic [CNTW-1:0] cnt_q, cnt_d;
    logic [TMRW-1:0] tmr_q, tmr_d;
    logic            store_q, store_d;
    logic            trig_q, trig_d;
    logic            done_q, done_d;
    logic            go;
    logic [LW-1:0]   go_lvl;

    logic [CNTW:0]   cnt_need;
    logic [CNTW:0]   cnt_next;
    logic            cnt_hit;
    logic [TMRW-1:0] tmr_inc;
    logic            tmr_last;
    logic            tmr_on;

    assign cnt_need = (count_i == '0) ? {{CNTW{1'b0}}, 1'b1} : {1'b0, count_i};
    assign cnt_next = {1'b0, cnt_q} + {{CNTW{1'b0}}, 1'b1};
    assign cnt_hit  = cnt_next >= cnt_need;
    assign tmr_inc  = tmr_q + {{(TMRW-1){1'b0}}, 1'b1};
    assign tmr_on   = timer_i != '0;
    assign tmr_last = tmr_on && (tmr_inc == timer_i);

    // next state, level, counter and timer
    always_comb begin
        state_d = state_q;
        lvl_d   = lvl_q;
        cnt_d   = cnt_q;
        tmr_d   = tmr_q;
        store_d = 1'b0;
        trig_d  = trig_q;
        done_d  = done_q;
        go      = 1'b0;
        go_lvl  = lvl_q;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_MATCH: begin
                if (smp_vld_i) begin
                    if (event_i && cnt_hit) begin
                        if (kind_i == KIND_DELAY && tmr_on) begin
                            state_d = ST_HOLD;
                            tmr_d   = '0;
                        end else begin
                            go     = 1'b1;
                            go_lvl = goto_ok_i;
                        end
                    end else begin
                        if (event_i) begin
                            cnt_d = cnt_next[CNTW-1:0];
                        end
                        if (kind_i == KIND_WINDOW && tmr_on) begin
                            if (tmr_last) begin
                                go     = 1'b1;
                                go_lvl = goto_fail_i;
                            end else begin
                                tmr_d = tmr_inc;
                            end
                        end
                    end
                end
            end
            ST_HOLD: begin
                if (smp_vld_i) begin
                    if (tmr_last || !tmr_on) begin
                        go     = 1'b1;
                        go_lvl = goto_ok_i;
                    end else begin
                        tmr_d = tmr_inc;
                    end
                end
            end
            ST_STORE: begin
                if (buf_full_i) begin
                    state_d = ST_DONE;
                    done_d  = 1'b1;
                end else if (smp_vld_i && match_i) begin
                    store_d = 1'b1;
                end
            end
            ST_DONE: begin
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
        if (arm_i) begin
            go      = 1'b1;
            go_lvl  = '0;
            trig_d  = 1'b0;
            done_d  = 1'b0;
            store_d = 1'b0;
        end
        if (go) begin
            lvl_d = go_lvl;
            cnt_d = '0;
            tmr_d = '0;
            if (tgt_kind_i == KIND_STORE) begin
                state_d = ST_STORE;
                trig_d  = 1'b1;
            end else begin
                state_d = ST_MATCH;
            end
        end
    end

    assign tgt_lvl_o  = go_lvl;
    assign hist_clr_o = go;

    // state register
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_IDLE;
            lvl_q   <= '0;
            cnt_q   <= '0;
            tmr_q   <= '0;
        end else begin
            state_q <= state_d;
            lvl_q   <= lvl_d;
            cnt_q   <= cnt_d;
            tmr_q   <= tmr_d;
        end
    end

    // output register
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            store_q <= 1'b0;
            trig_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            store_q <= store_d;
            trig_q  <= trig_d;
            done_q  <= done_d;
        end
    end

    assign store_o     = store_q;
    assign triggered_o = trig_q;
    assign done_o      = done_q;
    assign level_o     = lvl_q;

    assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_IDLE) |-> (!trig_q && !store_q && !done_q && lvl_q == '0));

    assert_arm_to_level0_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        arm_i |=> (lvl_q == '0 && !done_q));

    assert_window_timer_bound_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_MATCH && kind_i == KIND_WINDOW && tmr_on) |-> (tmr_q < timer_i));

    assert_store_needs_trigger_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        store_q |-> trig_q);

    assert_no_store_when_done_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        done_q |-> !store_q);

    assert_done_sticky_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        (done_q && !arm_i) |=> done_q);

    assert_trig_sticky_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        (trig_q && !arm_i) |=> trig_q);

    assert_level_hold_invalid_R12: assert property (@(posedge clk_i) disable iff (rst_i)
        (!smp_vld_i && !arm_i) |=> $stable(lvl_q));

endmodule

// File: rtl/trig_sequencer.sv
module trig_sequencer
    import trig_pkg::*;
#(
    parameter int NLVL = 4,
    parameter int DW   = 16,
    parameter int AW   = 16,
    parameter int CW   = 4,
    parameter int CNTW = 8,
    parameter int TMRW = 24,
    localparam int LW   = (NLVL > 1) ? $clog2(NLVL) : 1,
    localparam int SELW = (CW > 1) ? $clog2(CW) : 1
) (
    input  logic                   clk_i,
    input  logic                   rst_i,
    input  logic                   arm_i,
    input  logic                   smp_vld_i,
    input  logic [DW-1:0]          smp_data_i,
    input  logic [AW-1:0]          smp_addr_i,
    input  logic [CW-1:0]          smp_ctl_i,
    input  logic                   buf_full_i,
    input  logic [NLVL*2-1:0]      cfg_kind_i,
    input  logic [NLVL*3-1:0]      cfg_term_en_i,
    input  logic [NLVL-1:0]        cfg_or_mode_i,
    input  logic [NLVL*DW-1:0]     cfg_data_val_i,
    input  logic [NLVL*DW-1:0]     cfg_data_mask_i,
    input  logic [NLVL*AW-1:0]     cfg_addr_val_i,
    input  logic [NLVL*AW-1:0]     cfg_addr_mask_i,
    input  logic [NLVL*CW-1:0]     cfg_ctl_val_i,
    input  logic [NLVL*CW-1:0]     cfg_ctl_mask_i,
    input  logic [NLVL-1:0]        cfg_edge_en_i,
    input  logic [NLVL*SELW-1:0]   cfg_edge_sel_i,
    input  logic [NLVL*CNTW-1:0]   cfg_count_i,
    input  logic [NLVL*TMRW-1:0]   cfg_timer_i,
    input  logic [NLVL*LW-1:0]     cfg_goto_ok_i,
    input  logic [NLVL*LW-1:0]     cfg_goto_fail_i,
    output logic                   store_o,
    output logic                   triggered_o,
    output logic [LW-1:0]          level_o,
    output logic                   done_o
);

    lvl_kind_e         kind, tgt_kind;
    logic [LW-1:0]     cur_lvl, tgt_lvl;
    logic [TERM_N-1:0] term_en;
    logic              or_mode, edge_en;
    logic [DW-1:0]     data_val, data_mask;
    logic [AW-1:0]     addr_val, addr_mask;
    logic [CW-1:0]     ctl_val, ctl_mask;
    logic [SELW-1:0]   edge_sel;
    logic [CNTW-1:0]   count;
    logic [TMRW-1:0]   timer;
    logic [LW-1:0]     goto_ok, goto_fail;
    logic              match, rise, evt, hist_clr;

    trig_cfg_sel #(
        .NLVL(NLVL), .DW(DW), .AW(AW), .CW(CW), .CNTW(CNTW), .TMRW(TMRW)
    ) u_cfg (
        .lvl_i       (cur_lvl),
        .tgt_lvl_i   (tgt_lvl),
        .kind_i      (cfg_kind_i),
        .term_en_i   (cfg_term_en_i),
        .or_mode_i   (cfg_or_mode_i),
        .data_val_i  (cfg_data_val_i),
        .data_mask_i (cfg_data_mask_i),
        .addr_val_i  (cfg_addr_val_i),
        .addr_mask_i (cfg_addr_mask_i),
        .ctl_val_i   (cfg_ctl_val_i),
        .ctl_mask_i  (cfg_ctl_mask_i),
        .edge_en_i   (cfg_edge_en_i),
        .edge_sel_i  (cfg_edge_sel_i),
        .count_i     (cfg_count_i),
        .timer_i     (cfg_timer_i),
        .goto_ok_i   (cfg_goto_ok_i),
        .goto_fail_i (cfg_goto_fail_i),
        .kind_o      (kind),
        .tgt_kind_o  (tgt_kind),
        .term_en_o   (term_en),
        .or_mode_o   (or_mode),
        .data_val_o  (data_val),
        .data_mask_o (data_mask),
        .addr_val_o  (addr_val),
        .addr_mask_o (addr_mask),
        .ctl_val_o   (ctl_val),
        .ctl_mask_o  (ctl_mask),
        .edge_en_o   (edge_en),
        .edge_sel_o  (edge_sel),
        .count_o     (count),
        .timer_o     (timer),
        .goto_ok_o   (goto_ok),
        .goto_fail_o (goto_fail)
    );

    trig_cond #(.DW(DW), .AW(AW), .CW(CW)) u_cond (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .smp_vld_i   (smp_vld_i),
        .smp_data_i  (smp_data_i),
        .smp_addr_i  (smp_addr_i),
        .smp_ctl_i   (smp_ctl_i),
        .hist_clr_i  (hist_clr),
        .term_en_i   (term_en),
        .or_mode_i   (or_mode),
        .data_val_i  (data_val),
        .data_mask_i (data_mask),
        .addr_val_i  (addr_val),
        .addr_mask_i (addr_mask),
        .ctl_val_i   (ctl_val),
        .ctl_mask_i  (ctl_mask),
        .edge_en_i   (edge_en),
        .edge_sel_i  (edge_sel),
        .match_o     (match),
        .rise_o      (rise),
        .event_o     (evt)
    );

    trig_seq_fsm #(.NLVL(NLVL), .CNTW(CNTW), .TMRW(TMRW)) u_fsm (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .arm_i       (arm_i),
        .smp_vld_i   (smp_vld_i),
        .buf_full_i  (buf_full_i),
        .event_i     (evt),
        .match_i     (match),
        .kind_i      (kind),
        .tgt_kind_i  (tgt_kind),
        .count_i     (count),
        .timer_i     (timer),
        .goto_ok_i   (goto_ok),
        .goto_fail_i (goto_fail),
        .tgt_lvl_o   (tgt_lvl),
        .hist_clr_o  (hist_clr),
        .store_o     (store_o),
        .triggered_o (triggered_o),
        .level_o     (cur_lvl),
        .done_o      (done_o)
    );

    assign level_o = cur_lvl;

    // an edge event can only be reported while a rise is present (R5)
    assert_edge_event_needs_rise_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (edge_en && evt) |-> rise);

endmodule

// File: tb/trig_sequencer_bench.sv
module trig_sequencer_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic arm = 1'b0;
    logic vld = 1'b0;
    logic [15:0] sdata = '0;
    logic [15:0] saddr = '0;
    logic [3:0]  sctl  = '0;
    logic        full  = 1'b0;

    logic [7:0]  c_kind   = '0;
    logic [11:0] c_ten    = '0;
    logic [3:0]  c_or     = '0;
    logic [63:0] c_dv     = '0;
    logic [63:0] c_dm     = '0;
    logic [63:0] c_av     = '0;
    logic [63:0] c_am     = '0;
    logic [15:0] c_cv     = '0;
    logic [15:0] c_cm     = '0;
    logic [3:0]  c_ee     = '0;
    logic [7:0]  c_es     = '0;
    logic [31:0] c_cnt    = '0;
    logic [95:0] c_tmr    = '0;
    logic [7:0]  c_ok     = '0;
    logic [7:0]  c_fail   = '0;

    logic       st_o, tr_o, dn_o;
    logic [1:0] lv_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    trig_sequencer u_trig_sequencer (
        .clk_i(clk), .rst_i(rst), .arm_i(arm), .smp_vld_i(vld),
        .smp_data_i(sdata), .smp_addr_i(saddr), .smp_ctl_i(sctl), .buf_full_i(full),
        .cfg_kind_i(c_kind), .cfg_term_en_i(c_ten), .cfg_or_mode_i(c_or),
        .cfg_data_val_i(c_dv), .cfg_data_mask_i(c_dm),
        .cfg_addr_val_i(c_av), .cfg_addr_mask_i(c_am),
        .cfg_ctl_val_i(c_cv), .cfg_ctl_mask_i(c_cm),
        .cfg_edge_en_i(c_ee), .cfg_edge_sel_i(c_es),
        .cfg_count_i(c_cnt), .cfg_timer_i(c_tmr),
        .cfg_goto_ok_i(c_ok), .cfg_goto_fail_i(c_fail),
        .store_o(st_o), .triggered_o(tr_o), .level_o(lv_o), .done_o(dn_o)
    );

    // {vld, data, addr, ctl, full, exp_store, exp_trig, exp_level, exp_done}
    function automatic logic [42:0] mkv(input logic v, input logic [15:0] d, input logic [15:0] a,
                                        input logic [3:0] c, input logic f, input logic es,
                                        input logic et, input logic [1:0] el, input logic ed);
        return {v, d, a, c, f, es, et, el, ed};
    endfunction

    // reference program: L0 data==3D, L1 4 write rises in 10 samples, L2 store addr==56
    localparam logic [42:0] TBL [16] = '{
        mkv(1'b1, 16'h0011, 16'h0000, 4'h0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0),
        mkv(1'b1, 16'h003D, 16'h0000, 4'h0, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0),
        mkv(1'b1, 16'h0000, 16'h0000, 4'h0, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0),
        mkv(1'b1, 16'h0000, 16'h0000, 4'h2, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0),
        mkv(1'b1, 16'h0000, 16'h0000, 4'h0, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0),
        mkv(1'b1, 16'h0000, 16'h0000, 4'h2, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0),
        mkv(1'b1, 16'h0000, 16'h0000, 4'h0, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0),
        mkv(1'b1, 16'h0000, 16'h0000, 4'h2, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0),
        mkv(1'b1, 16'h0000, 16'h0000, 4'h0, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0),
        mkv(1'b1, 16'h0000, 16'h0000, 4'h2, 1'b0, 1'b0, 1'b1, 2'd2, 1'b0),
        mkv(1'b1, 16'h0000, 16'h0056, 4'h0, 1'b0, 1'b1, 1'b1, 2'd2, 1'b0),
        mkv(1'b1, 16'h0000, 16'h0057, 4'h0, 1'b0, 1'b0, 1'b1, 2'd2, 1'b0),
        mkv(1'b0, 16'h0000, 16'h0056, 4'h0, 1'b0, 1'b0, 1'b1, 2'd2, 1'b0),
        mkv(1'b1, 16'h0000, 16'h0056, 4'h0, 1'b0, 1'b1, 1'b1, 2'd2, 1'b0),
        mkv(1'b1, 16'h0000, 16'h0056, 4'h0, 1'b1, 1'b0, 1'b1, 2'd2, 1'b1),
        mkv(1'b1, 16'h0000, 16'h0056, 4'h0, 1'b0, 1'b0, 1'b1, 2'd2, 1'b1)
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_lvl(input int i, input logic [1:0] kind, input logic [2:0] ten,
                           input logic orm, input logic [15:0] dv, input logic [15:0] av,
                           input logic ee, input logic [1:0] sel, input logic [7:0] cnt,
                           input logic [23:0] tmr, input logic [1:0] ok, input logic [1:0] fl);
        c_kind[i*2 +: 2]  = kind;
        c_ten[i*3 +: 3]   = ten;
        c_or[i]           = orm;
        c_dv[i*16 +: 16]  = dv;
        c_dm[i*16 +: 16]  = 16'hFFFF;
        c_av[i*16 +: 16]  = av;
        c_am[i*16 +: 16]  = 16'hFFFF;
        c_ee[i]           = ee;
        c_es[i*2 +: 2]    = sel;
        c_cnt[i*8 +: 8]   = cnt;
        c_tmr[i*24 +: 24] = tmr;
        c_ok[i*2 +: 2]    = ok;
        c_fail[i*2 +: 2]  = fl;
    endtask

    task automatic step(input logic v, input logic [15:0] d, input logic [15:0] a,
                        input logic [3:0] c, input logic f);
        vld = v; sdata = d; saddr = a; sctl = c; full = f;
        @(negedge clk);
    endtask

    task automatic do_arm();
        vld = 1'b0; full = 1'b0; arm = 1'b1;
        @(negedge clk);
        arm = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // reference program (write line = ctl bit 1)
        set_lvl(0, 2'd0, 3'b001, 1'b0, 16'h003D, 16'h0, 1'b0, 2'd0, 8'd1, 24'd0, 2'd1, 2'd0);
        set_lvl(1, 2'd1, 3'b000, 1'b0, 16'h0, 16'h0, 1'b1, 2'd1, 8'd4, 24'd10, 2'd2, 2'd0);
        set_lvl(2, 2'd3, 3'b010, 1'b0, 16'h0, 16'h0056, 1'b0, 2'd0, 8'd0, 24'd0, 2'd0, 2'd0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 reset level", lv_o, 0);
        chk("R1 reset trig", tr_o, 0);
        chk("R1 reset done", dn_o, 0);
        chk("R1 reset store", st_o, 0);

        // R1: matching sample before arm has no effect
        step(1'b1, 16'h003D, 16'h0, 4'h0, 1'b0);
        chk("R1 idle ignores sample", lv_o, 0);

        do_arm();
        chk("R2 arm level", lv_o, 0);

        for (int i = 0; i < 16; i++) begin
            logic [42:0] e;
            e = TBL[i];
            step(e[42], e[41:26], e[25:10], e[9:6], e[5]);
            chk("R8 table store", st_o, e[4]);
            chk("R10 table trig", tr_o, e[3]);
            chk("R3 table level", lv_o, e[2:1]);
            chk("R9 table done", dn_o, e[0]);
        end

        // R2: arm clears done and triggered
        do_arm();
        chk("R2 arm clears done", dn_o, 0);
        chk("R2 arm clears trig", tr_o, 0);
        chk("R2 arm level0", lv_o, 0);

        // R6 timeout with only two rises, R12 invalid samples inside window
        step(1'b1, 16'h003D, 16'h0, 4'h0, 1'b0);
        chk("R11 enter level1", lv_o, 1);
        step(1'b1, 16'h0, 16'h0, 4'h0, 1'b0);
        step(1'b1, 16'h0, 16'h0, 4'h2, 1'b0);
        step(1'b1, 16'h0, 16'h0, 4'h0, 1'b0);
        step(1'b1, 16'h0, 16'h0, 4'h2, 1'b0);
        for (int k = 5; k <= 9; k++) step(1'b1, 16'h0, 16'h0, 4'h2, 1'b0);
        chk("R6 still in window after 9", lv_o, 1);
        for (int k = 0; k < 4; k++) step(1'b0, 16'h0, 16'h0, 4'h0, 1'b0);
        chk("R12 invalid samples no timeout", lv_o, 1);
        step(1'b1, 16'h0, 16'h0, 4'h2, 1'b0);
        chk("R6 timeout to fail level", lv_o, 0);
        chk("R6 no trigger on timeout", tr_o, 0);

        // R6 count reached on the exact last window sample
        step(1'b1, 16'h003D, 16'h0, 4'h0, 1'b0);
        for (int k = 1; k <= 6; k++) step(1'b1, 16'h0, 16'h0, (k % 2 == 0) ? 4'h2 : 4'h0, 1'b0);
        step(1'b1, 16'h0, 16'h0, 4'h0, 1'b0);
        step(1'b1, 16'h0, 16'h0, 4'h0, 1'b0);
        step(1'b1, 16'h0, 16'h0, 4'h0, 1'b0);
        chk("R6 three rises still level1", lv_o, 1);
        step(1'b1, 16'h0, 16'h0, 4'h2, 1'b0);
        chk("R6 success on last sample", lv_o, 2);
        chk("R10 trig on store entry", tr_o, 1);

        // R5 edge history cleared on transition; R4 next level sees later samples only
        do_arm();
        step(1'b1, 16'h003D, 16'h0, 4'h0, 1'b0);
        step(1'b1, 16'h0, 16'h0, 4'h2, 1'b0);
        for (int k = 0; k < 3; k++) begin
            step(1'b1, 16'h0, 16'h0, 4'h0, 1'b0);
            step(1'b1, 16'h0, 16'h0, 4'h2, 1'b0);
        end
        chk("R5 first sample is not a rise", lv_o, 1);
        step(1'b1, 16'h0, 16'h0, 4'h0, 1'b0);
        step(1'b1, 16'h0, 16'h0, 4'h2, 1'b0);
        chk("R5 fourth rise advances", lv_o, 2);

        // R7 delay level, R4 samples in the wait not evaluated, R3 OR mode
        set_lvl(0, 2'd2, 3'b001, 1'b0, 16'h00AA, 16'h0, 1'b0, 2'd0, 8'd3, 24'd5, 2'd1, 2'd0);
        set_lvl(1, 2'd0, 3'b011, 1'b1, 16'h00BB, 16'h0077, 1'b0, 2'd0, 8'd1, 24'd0, 2'd2, 2'd0);
        do_arm();
        step(1'b1, 16'h00AA, 16'h0, 4'h0, 1'b0);
        step(1'b1, 16'h0000, 16'h0, 4'h0, 1'b0);
        step(1'b1, 16'h00AA, 16'h0, 4'h0, 1'b0);
        chk("R3 count not yet reached", lv_o, 0);
        step(1'b1, 16'h00AA, 16'h0, 4'h0, 1'b0);
        for (int k = 1; k <= 4; k++) step(1'b1, 16'h0, 16'h0077, 4'h0, 1'b0);
        chk("R7 waiting during delay", lv_o, 0);
        step(1'b1, 16'h0, 16'h0077, 4'h0, 1'b0);
        chk("R7 delay done to ok level", lv_o, 1);
        step(1'b1, 16'h0, 16'h0, 4'h0, 1'b0);
        chk("R4 wait samples not evaluated", lv_o, 1);
        step(1'b1, 16'h0, 16'h0077, 4'h0, 1'b0);
        chk("R3 OR mode address term", lv_o, 2);
        step(1'b1, 16'h0, 16'h0056, 4'h0, 1'b0);
        chk("R8 store after reprogram", st_o, 1);
        step(1'b0, 16'h0, 16'h0, 4'h0, 1'b0);
        chk("R8 store pulse one cycle", st_o, 0);

        finish_run();
    end

endmodule